// File: doc/BRIEF.md
# Frame display address generator

This block produces the display-memory read address for a raster video controller. The host programs a 16-bit start address as two byte-wide registers, plus a byte-wide line offset. The block watches the vertical sync input. On each rising edge of vertical sync it copies the programmed start address into an internal line base and display pointer. Host writes made later in the frame have no effect until the next rising edge. Because of this, a start address that has only been half rewritten never reaches the pointer in the middle of a frame.

While display-enable is high, the pointer steps by one byte per clock. Each horizontal-end strobe moves the line base forward by the line offset and reloads the pointer from the new base. As a result, the line pitch is set by the offset and not by how many bytes were fetched. A line counter is cleared at vertical sync and advances on each horizontal end. When the line about to start has the number given on the split-line input, the base and the pointer are forced to zero. Later lines count onward from zero. All address arithmetic wraps modulo 65536.

The controller has three states:
- `ST_IDLE`: after reset, before any vertical sync has been seen. The pointer stays at zero.
- `ST_TOP`: the frame area above the split.
- `ST_LOWER`: the frame area below the split.

Transitions:
- `IDLE->TOP` on the first vertical sync rise.
- `TOP->LOWER` on a split hit.
- `TOP->TOP` and `LOWER->TOP` on every later vertical sync rise.
- Every other case holds the current state.

Top module: `disp_addr_gen`

## Requirements
- R1: While reset is asserted and directly after it, `mem_addr` is 0 and the controller is in ST_IDLE.
- R2: A host write with index 0x0C sets the start high byte. Index 0x0D sets the start low byte. Index 0x13 sets the line offset. Writes to any other index change nothing that is later visible on `mem_addr`.
- R3: In the clock after a rising edge of `vsync`, `mem_addr` equals {high, low} as held before that edge. Holding `vsync` high does not reload.
- R4: A register write made in the same cycle as the rise, or later in the frame, reaches `mem_addr` only at the next rise.
- R5: With no rise and no `hend`, `mem_addr` increments by 1 each clock that `de` is high and holds when `de` is low.
- R6: On `hend` without a split hit, the line base grows by the line offset (zero-extended), and `mem_addr` becomes the new base, whatever the number of bytes stepped.
- R7: In ST_TOP, when `hend` makes the line count (0 at the rise, +1 per `hend`) equal to `split_line`, `mem_addr` becomes 0 and the state becomes ST_LOWER. Later lines step from base 0, and no second split occurs in that frame.
- R8: The pointer and the line base wrap modulo 65536.
- R9: A `vsync` rise takes priority over `hend`, and `hend` takes priority over `de`, when they coincide.
- R10: In ST_IDLE, `de` and `hend` leave `mem_addr` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_idx | input | 8 | Host register index |
| reg_wdata | input | 8 | Host write data |
| vsync | input | 1 | Vertical sync level |
| hend | input | 1 | One-clock horizontal-end strobe |
| de | input | 1 | Display enable |
| split_line | input | LINE_W (10) | Line number at which the pointer restarts at zero |
| mem_addr | output | 16 | Display-memory read address |

## Verification
The assertions take for granted that `hend` is a single-clock strobe. They also assume that `split_line` stays steady while a frame is in the area above the split, so that a split hit matches the value the host intended. The stimulus changes `split_line` only while `vsync` is low between frames, and it raises `hend` for exactly one clock per line. `hend` is deliberately driven together with `de` and with a `vsync` rise to exercise the priority order. Register writes are issued both mid-frame and in the same cycle as a rise, so that the deferred-load rule is exercised at its edge.

// File: rtl/fdag_pkg.sv
package fdag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TOP   = 2'd1,
        ST_LOWER = 2'd2
    } fdag_state_e;

    localparam logic [7:0] IDX_START_HI = 8'h0C;
    localparam logic [7:0] IDX_START_LO = 8'h0D;
    localparam logic [7:0] IDX_LINE_OFS = 8'h13;

endpackage

// File: rtl/fdag_regs.sv
module fdag_regs
    import fdag_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    parameter int HALVES = 2,
    localparam int ADDR_W = DATA_W * HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] start_addr,
    output logic [DATA_W-1:0] line_ofs
);

    // Start address halves: half h (0 = least significant) lives at
    // index IDX_START_LO - h, so the high byte sits one index below.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX_START_LO) - IDX_W'(h);
        logic [DATA_W-1:0] half_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                half_q <= '0;
            end else if (wr_en && (wr_idx == MY_IDX)) begin
                half_q <= wr_data;
            end
        end

        assign start_addr[h*DATA_W +: DATA_W] = half_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_ofs <= '0;
        end else if (wr_en && (wr_idx == IDX_W'(IDX_LINE_OFS))) begin
            line_ofs <= wr_data;
        end
    end

endmodule

// File: rtl/fdag_timing.sv
module fdag_timing #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic              hend,
    output logic              load_evt,
    output logic              line_adv,
    output logic [LINE_W-1:0] next_line
);

    logic              vsync_q;
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsync_q <= 1'b0;
        end else begin
            vsync_q <= vsync;
        end
    end

    // Leading edge of vertical sync; a line end in the same cycle is dropped.
    assign load_evt  = vsync && !vsync_q;
    assign line_adv  = hend && !load_evt;
    assign next_line = line_q + LINE_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (load_evt) begin
            line_q <= '0;
        end else if (line_adv) begin
            line_q <= next_line;
        end
    end

endmodule

// File: rtl/fdag_ctrl.sv
module fdag_ctrl
    import fdag_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_evt,
    input  logic              line_adv,
    input  logic              de,
    input  logic [LINE_W-1:0] next_line,
    input  logic [LINE_W-1:0] split_line,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [OFS_W-1:0]  line_ofs,
    output logic [ADDR_W-1:0] addr,
    output fdag_state_e       state
);

    localparam int PAD_W = ADDR_W - OFS_W;

    fdag_state_e       state_d;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] stepped_base;
    logic [ADDR_W-1:0] base_next;
    logic              split_hit;

    assign stepped_base = base_q + {{PAD_W{1'b0}}, line_ofs};
    assign split_hit    = (state == ST_TOP) && line_adv && (next_line == split_line);
    assign base_next    = split_hit ? '0 : stepped_base;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Next-state decode
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  if (load_evt) state_d = ST_TOP;
            ST_TOP: begin
                if (load_evt)       state_d = ST_TOP;
                else if (split_hit) state_d = ST_LOWER;
            end
            ST_LOWER: if (load_evt) state_d = ST_TOP;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output datapath: line base and display pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr_q  <= '0;
        end else if (load_evt) begin
            base_q <= start_addr;
            ptr_q  <= start_addr;
        end else if (state != ST_IDLE) begin
            if (line_adv) begin
                base_q <= base_next;
                ptr_q  <= base_next;
            end else if (de) begin
                ptr_q <= ptr_q + ADDR_W'(1);
            end
        end
    end

    assign addr = ptr_q;

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (addr == '0));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_evt && !line_adv && !de) |=> $stable(addr));

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && !load_evt && !line_adv && de) |=> (addr == $past(addr) + ADDR_W'(1)));

    assert_split_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_TOP) && !load_evt && line_adv && (next_line == split_line))
        |=> ((addr == '0) && (state == ST_LOWER)));

    assert_no_second_split_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_LOWER) && !load_evt) |=> (state == ST_LOWER));

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_evt |=> (state == ST_TOP));

endmodule

// File: rtl/disp_addr_gen.sv
module disp_addr_gen
    import fdag_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINE_W = 10,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              vsync,
    input  logic              hend,
    input  logic              de,
    input  logic [LINE_W-1:0] split_line,
    output logic [ADDR_W-1:0] mem_addr
);

    logic [ADDR_W-1:0] start_addr;
    logic [DATA_W-1:0] line_ofs;
    logic              load_evt;
    logic              line_adv;
    logic [LINE_W-1:0] next_line;
    fdag_state_e       state;

    fdag_regs #(.DATA_W(DATA_W), .IDX_W(8), .HALVES(2)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wr_idx     (reg_idx),
        .wr_data    (reg_wdata),
        .start_addr (start_addr),
        .line_ofs   (line_ofs)
    );

    fdag_timing #(.LINE_W(LINE_W)) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync     (vsync),
        .hend      (hend),
        .load_evt  (load_evt),
        .line_adv  (line_adv),
        .next_line (next_line)
    );

    fdag_ctrl #(.ADDR_W(ADDR_W), .OFS_W(DATA_W), .LINE_W(LINE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_evt   (load_evt),
        .line_adv   (line_adv),
        .de         (de),
        .next_line  (next_line),
        .split_line (split_line),
        .start_addr (start_addr),
        .line_ofs   (line_ofs),
        .addr       (mem_addr),
        .state      (state)
    );

    assert_vs_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_evt |=> (mem_addr == $past(start_addr)));

    assert_held_vsync_no_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && $past(vsync) && !hend && !de && (state != ST_IDLE)) |=> $stable(mem_addr));

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> ((mem_addr == '0) && (state == ST_IDLE)));

endmodule

// File: tb/disp_addr_gen_bench.sv
module disp_addr_gen_bench;

    localparam int LINE_W = 10;
    localparam int LMASK  = (1 << LINE_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              reg_wr;
    logic [7:0]        reg_idx;
    logic [7:0]        reg_wdata;
    logic              vsync;
    logic              hend;
    logic              de;
    logic [LINE_W-1:0] split_line;
    logic [15:0]       mem_addr;

    always #10 clk = ~clk;

    disp_addr_gen #(.DATA_W(8), .LINE_W(LINE_W)) u_disp_addr_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_idx    (reg_idx),
        .reg_wdata  (reg_wdata),
        .vsync      (vsync),
        .hend       (hend),
        .de         (de),
        .split_line (split_line),
        .mem_addr   (mem_addr)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // Behavioural reference state
    int m_hi = 0, m_lo = 0, m_off = 0, m_vsq = 0;
    int m_line = 0, m_base = 0, m_ptr = 0;
    int m_state = 0; // 0 idle, 1 top, 2 lower

    task automatic model_step();
        int start, rise, adv, nline;
        start = (m_hi << 8) | m_lo;
        rise  = (vsync && (m_vsq == 0)) ? 1 : 0;
        m_vsq = vsync ? 1 : 0;
        adv   = (hend && rise == 0) ? 1 : 0;
        nline = (m_line + 1) & LMASK;
        if (rise != 0) begin
            m_base = start; m_ptr = start; m_line = 0; m_state = 1;
        end else begin
            if (adv != 0) m_line = nline;
            if (m_state != 0) begin
                if (adv != 0) begin
                    if (m_state == 1 && nline == int'(split_line)) begin
                        m_base = 0; m_state = 2;
                    end else begin
                        m_base = (m_base + m_off) & 16'hFFFF;
                    end
                    m_ptr = m_base;
                end else if (de) begin
                    m_ptr = (m_ptr + 1) & 16'hFFFF;
                end
            end
        end
        if (reg_wr) begin
            if (reg_idx == 8'h0C) m_hi  = int'(reg_wdata);
            if (reg_idx == 8'h0D) m_lo  = int'(reg_wdata);
            if (reg_idx == 8'h13) m_off = int'(reg_wdata);
        end
    endtask

    task automatic compare();
        n_cmp++;
        if (mem_addr !== 16'(m_ptr)) begin
            n_bad++;
            $display("FAIL %s: mem_addr actual %h expected %h at %0t", cur_req, mem_addr, 16'(m_ptr), $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) model_step();
        #1;
        compare();
        reg_wr = 1'b0;
        hend   = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wreg(input logic [7:0] idx, input logic [7:0] val);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = val;
        tick();
    endtask

    task automatic do_line(input int nbytes);
        de = 1'b1; ticks(nbytes);
        de = 1'b0; ticks(1);
        hend = 1'b1; tick();
    endtask

    task automatic frame_rise();
        vsync = 1'b1; tick();
        ticks(2);
        vsync = 1'b0; tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, actual cycles 100000 expected fewer");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_idx = '0; reg_wdata = '0;
        vsync = 1'b0; hend = 1'b0; de = 1'b0; split_line = 10'd500;

        // R1: reset state
        cur_req = "R1";
        ticks(3);
        rst_n = 1'b1;
        tick();

        // R10: idle ignores de and hend
        cur_req = "R10";
        de = 1'b1; ticks(5);
        hend = 1'b1; tick();
        de = 1'b0; ticks(2);

        // R2: register writes, stray indices ignored
        cur_req = "R2";
        wreg(8'h0C, 8'h12);
        wreg(8'h0D, 8'h34);
        wreg(8'h13, 8'h50);
        wreg(8'h0E, 8'hFF);
        wreg(8'h0B, 8'h77);
        wreg(8'h14, 8'h01);

        // R3: load at vsync rise, held vsync does not reload
        cur_req = "R3";
        vsync = 1'b1; tick();
        ticks(3);
        de = 1'b1; ticks(3);
        de = 1'b0; ticks(2);
        vsync = 1'b0; tick();

        // R5: byte stepping and hold
        cur_req = "R5";
        de = 1'b1; ticks(7);
        de = 1'b0; ticks(3);
        de = 1'b1; ticks(2);
        de = 1'b0;

        // R6: line advance by offset, independent of byte count
        cur_req = "R6";
        hend = 1'b1; tick();
        do_line(3);
        do_line(40);
        do_line(0);

        // R4: mid-frame write deferred; write in rise cycle deferred
        cur_req = "R4";
        wreg(8'h0C, 8'h40);
        do_line(4);
        vsync = 1'b1; reg_wr = 1'b1; reg_idx = 8'h0D; reg_wdata = 8'h99; tick();
        vsync = 1'b0; ticks(2);
        do_line(5);
        frame_rise();
        do_line(2);

        // R7: split line restarts at zero, once per frame
        cur_req = "R7";
        split_line = 10'd3;
        frame_rise();
        for (int l = 0; l < 6; l++) do_line(l + 1);
        split_line = 10'd1;
        frame_rise();
        do_line(2);
        do_line(2);
        split_line = 10'd500;

        // R8: wrap modulo 65536
        cur_req = "R8";
        wreg(8'h0C, 8'hFF);
        wreg(8'h0D, 8'hF0);
        wreg(8'h13, 8'h20);
        frame_rise();
        de = 1'b1; ticks(20);
        de = 1'b0;
        hend = 1'b1; tick();
        do_line(3);
        do_line(3);

        // R9: priority of rise over hend over de
        cur_req = "R9";
        wreg(8'h0C, 8'h20);
        wreg(8'h0D, 8'h00);
        de = 1'b1; vsync = 1'b1; hend = 1'b1; tick();
        vsync = 1'b0; ticks(3);
        hend = 1'b1; tick();
        ticks(2);
        hend = 1'b1; tick();
        de = 1'b0; ticks(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule